// File: doc/BRIEF.md
# Byte-wide configuration port loader (full and partial)

This block is the master side of a parallel, byte-wide configuration port on a programmable logic device. It takes configuration bytes from an upstream byte stream with a valid/ready handshake and drives the target's active-low clear, select and write lines, a byte strobe and an 8-bit data bus. A load is started with a one-cycle `start` request, and `partial_mode` chooses the kind of load at that moment.

A full load first pulses the clear line low for a fixed number of cycles. It then waits until the target reports that it is ready. The target may never report ready, so the wait is bounded, and when the bound runs out the controller raises a failure flag and goes back to idle. A partial load never touches the clear line, because clearing would wipe the whole device, including the logic that is doing the loading. It also skips the ready wait and opens the port at once. Both kinds of load then send a few filler bytes, the eight-byte synchronisation sequence and the payload. After that the port is released and a done pulse is given.

Top module: `cfg_port_loader`

## Requirements
- R1: While `rst` is high and afterwards in idle, `tgt_clear_n`, `tgt_sel_n` and `tgt_wr_n` are 1, and `tgt_stb`, `s_ready`, `busy` and `done` are 0.
- R2: When `start` is sampled high in idle with `partial_mode` low, `tgt_clear_n` is 0 for exactly CLEAR_CYCLES cycles, beginning with the cycle after that edge. The port stays closed during this pulse.
- R3: In a full load, the port stays closed while `tgt_ready` is sampled low after the clear pulse. On the first edge that samples it high, `tgt_sel_n` and `tgt_wr_n` both go to 0 together.
- R4: In a partial load, `tgt_clear_n` stays 1 for the whole load and `tgt_ready` is ignored. `tgt_sel_n` and `tgt_wr_n` go to 0 in the cycle after `start` is sampled.
- R5: Once the port is open, the header goes out on `tgt_data` one byte per cycle with `tgt_stb` high. It is PAD_COUNT copies of PAD_BYTE (defaults: 2 and 0xFF), then FF FF FF FF AA 99 55 66, sent in that order with the most significant byte of the sync word first.
- R6: `s_ready` is high only in the payload phase. Each byte accepted while `s_valid` is high appears on `tgt_data` with `tgt_stb` high in the next cycle. Cycles in which `s_valid` is low give no strobe, and the port stays open through them.
- R7: The payload ends with the byte that has `s_last` high. In the cycle after that byte's strobe, `tgt_sel_n` and `tgt_wr_n` return to 1. `done` is high for exactly one cycle, the cycle after that.
- R8: If `tgt_ready` stays low for WAIT_LIMIT consecutive wait cycles, `fail` goes to 1 and the controller returns to idle without opening the port or pulsing `done`. `fail` is cleared by the next accepted `start`.
- R9: `start` is ignored while `busy` is high. `partial_mode` is sampled only when a start is accepted, so changing it during a load has no effect.
- R10: `tgt_stb` is high only while both `tgt_sel_n` and `tgt_wr_n` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a load; acted on only when idle |
| partial_mode | input | 1 | 1 selects a partial load, 0 a full load; sampled with start |
| s_data | input | 8 | Upstream payload byte |
| s_valid | input | 1 | Upstream byte is valid |
| s_last | input | 1 | Upstream byte is the final payload byte |
| s_ready | output | 1 | Loader accepts an upstream byte this cycle |
| tgt_ready | input | 1 | Target reports that it can take data after a clear |
| tgt_clear_n | output | 1 | Active-low clear request to the target |
| tgt_sel_n | output | 1 | Active-low port select |
| tgt_wr_n | output | 1 | Active-low write direction select |
| tgt_stb | output | 1 | A byte is presented on tgt_data this cycle |
| tgt_data | output | 8 | Configuration byte to the target |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse after the port is released |
| fail | output | 1 | The ready wait timed out; held until the next start |

## Verification
A partial load with an unbroken payload shows the shortest path, with no clear pulse and the port opening at once. A full load with the ready input delayed by several cycles and a payload with periodic valid gaps separates the clear pulse, the wait and stall handling from the header timing. A full load in which ready never arrives shows the timeout, and the partial load that follows shows the flag being cleared. Two more cases cover the remaining behaviour: a start request issued during a partial load, with the mode input changed, shows that both are ignored, and a full load whose ready is already high shows the shortest possible wait.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_WAIT,
    ST_HDR,
    ST_DATA,
    ST_CLOSE,
    ST_DONE
  } ld_state_t;

  localparam int SYNC_LEN = 8;
  localparam logic [63:0] SYNC_SEQ = 64'hFFFF_FFFF_AA99_5566;

  // Byte k of the sync sequence, most significant byte first.
  function automatic logic [7:0] sync_byte(input logic [2:0] k);
    return SYNC_SEQ[63 - 8*int'(k) -: 8];
  endfunction

endpackage

// File: rtl/cfg_loader_timer.sv
module cfg_loader_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = run && (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/cfg_loader_header.sv
module cfg_loader_header
  import cfg_loader_pkg::*;
#(
  parameter int          PAD_COUNT = 2,
  parameter logic [7:0]  PAD_BYTE  = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       advance,
  output logic [7:0] hdr_byte,
  output logic       hdr_last
);
  localparam int HLEN = PAD_COUNT + SYNC_LEN;
  localparam int IW   = $clog2(HLEN + 1);

  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (restart) begin
      idx <= '0;
    end else if (advance) begin
      idx <= idx + 1'b1;
    end
  end

  assign hdr_last = (idx == IW'(HLEN - 1));

  generate
    if (PAD_COUNT == 0) begin : g_nopad
      assign hdr_byte = sync_byte(idx[2:0]);
    end else begin : g_pad
      logic [IW-1:0] rel;
      assign rel      = idx - IW'(PAD_COUNT);
      assign hdr_byte = (idx < IW'(PAD_COUNT)) ? PAD_BYTE : sync_byte(rel[2:0]);
    end
  endgenerate

endmodule

// File: rtl/cfg_port_loader.sv
module cfg_port_loader
  import cfg_loader_pkg::*;
#(
  parameter int         CLEAR_CYCLES = 4,
  parameter int         WAIT_LIMIT   = 1000,
  parameter int         PAD_COUNT    = 2,
  parameter logic [7:0] PAD_BYTE     = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       partial_mode,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  input  logic       tgt_ready,
  output logic       tgt_clear_n,
  output logic       tgt_sel_n,
  output logic       tgt_wr_n,
  output logic       tgt_stb,
  output logic [7:0] tgt_data,
  output logic       busy,
  output logic       done,
  output logic       fail
);

  ld_state_t  state;
  logic       go_full;
  logic       go_part;
  logic       clear_exp;
  logic       wait_exp;
  logic       open_port;
  logic       hdr_adv;
  logic [7:0] hdr_byte;
  logic       hdr_last;

  assign go_full   = (state == ST_IDLE) && start && !partial_mode;
  assign go_part   = (state == ST_IDLE) && start && partial_mode;
  assign open_port = go_part || ((state == ST_WAIT) && tgt_ready);
  assign hdr_adv   = (state == ST_HDR);

  cfg_loader_timer #(.LIMIT(CLEAR_CYCLES)) u_clear_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (go_full),
    .run     (state == ST_CLEAR),
    .expired (clear_exp)
  );

  cfg_loader_timer #(.LIMIT(WAIT_LIMIT)) u_wait_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (clear_exp),
    .run     (state == ST_WAIT),
    .expired (wait_exp)
  );

  cfg_loader_header #(.PAD_COUNT(PAD_COUNT), .PAD_BYTE(PAD_BYTE)) u_hdr (
    .clk      (clk),
    .rst      (rst),
    .restart  (open_port),
    .advance  (hdr_adv),
    .hdr_byte (hdr_byte),
    .hdr_last (hdr_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      tgt_clear_n <= 1'b1;
      tgt_sel_n   <= 1'b1;
      tgt_wr_n    <= 1'b1;
      tgt_stb     <= 1'b0;
      tgt_data    <= '0;
      done        <= 1'b0;
      fail        <= 1'b0;
    end else begin
      done    <= 1'b0;
      tgt_stb <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (go_full) begin
            fail        <= 1'b0;
            tgt_clear_n <= 1'b0;
            state       <= ST_CLEAR;
          end else if (go_part) begin
            fail      <= 1'b0;
            tgt_sel_n <= 1'b0;
            tgt_wr_n  <= 1'b0;
            state     <= ST_HDR;
          end
        end
        ST_CLEAR: begin
          if (clear_exp) begin
            tgt_clear_n <= 1'b1;
            state       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (tgt_ready) begin
            tgt_sel_n <= 1'b0;
            tgt_wr_n  <= 1'b0;
            state     <= ST_HDR;
          end else if (wait_exp) begin
            fail  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_HDR: begin
          tgt_stb  <= 1'b1;
          tgt_data <= hdr_byte;
          if (hdr_last) begin
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          tgt_stb <= s_valid;
          if (s_valid) begin
            tgt_data <= s_data;
            if (s_last) begin
              state <= ST_CLOSE;
            end
          end
        end
        ST_CLOSE: begin
          tgt_sel_n <= 1'b1;
          tgt_wr_n  <= 1'b1;
          state     <= ST_DONE;
        end
        ST_DONE: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign s_ready = (state == ST_DATA);
  assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic partial_mode,
  input logic s_ready,
  input logic tgt_clear_n,
  input logic tgt_sel_n,
  input logic tgt_wr_n,
  input logic tgt_stb,
  input logic busy,
  input logic done,
  input logic fail
);
  logic mode_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r <= 1'b0;
    end else if (start && !busy) begin
      mode_r <= partial_mode;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (tgt_sel_n && tgt_wr_n && !tgt_stb && !s_ready));

  assert_closed_in_clear_R2: assert property (@(posedge clk) disable iff (rst)
    !tgt_clear_n |-> (tgt_sel_n && tgt_wr_n));

  assert_partial_no_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_r) |-> tgt_clear_n);

  assert_ready_port_open_R6: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> !tgt_sel_n);

  assert_done_released_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (tgt_sel_n && tgt_wr_n && !busy));

  assert_timeout_closed_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> (tgt_sel_n && !busy && !done));

  assert_strobe_open_R10: assert property (@(posedge clk) disable iff (rst)
    tgt_stb |-> (!tgt_sel_n && !tgt_wr_n));

endmodule

bind cfg_port_loader cfg_loader_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .partial_mode (partial_mode),
  .s_ready      (s_ready),
  .tgt_clear_n  (tgt_clear_n),
  .tgt_sel_n    (tgt_sel_n),
  .tgt_wr_n     (tgt_wr_n),
  .tgt_stb      (tgt_stb),
  .busy         (busy),
  .done         (done),
  .fail         (fail)
);

// File: tb/cfg_port_loader_bench.sv
module cfg_port_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLR_N      = 4;
  localparam int WAIT_N     = 12;
  localparam int PAD_N      = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       partial_mode = 1'b0;
  logic [7:0] s_data = '0;
  logic       s_valid = 1'b0;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic       tgt_ready = 1'b0;
  logic       tgt_clear_n, tgt_sel_n, tgt_wr_n, tgt_stb;
  logic [7:0] tgt_data;
  logic       busy, done, fail;

  int total = 0;
  int bad   = 0;
  int done_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_loader #(
    .CLEAR_CYCLES(CLR_N), .WAIT_LIMIT(WAIT_N), .PAD_COUNT(PAD_N), .PAD_BYTE(8'hFF)
  ) u_cfg_port_loader (
    .clk(clk), .rst(rst), .start(start), .partial_mode(partial_mode),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .tgt_ready(tgt_ready), .tgt_clear_n(tgt_clear_n), .tgt_sel_n(tgt_sel_n),
    .tgt_wr_n(tgt_wr_n), .tgt_stb(tgt_stb), .tgt_data(tgt_data),
    .busy(busy), .done(done), .fail(fail)
  );

  // Behavioural reference model
  int         m_phase = 0;  // 0 idle 1 clear 2 wait 3 header 4 payload 5 close 6 done
  int         m_cnt = 0;
  bit         m_partial = 0;
  logic [7:0] m_hdr[$];
  logic       e_clear_n = 1, e_sel_n = 1, e_stb = 0, e_done = 0, e_fail = 0;
  logic [7:0] e_data = 0;
  string      e_tag = "R5";

  task automatic fill_header();
    logic [63:0] sw = 64'hFFFF_FFFF_AA99_5566;
    m_hdr.delete();
    for (int i = 0; i < PAD_N; i++) m_hdr.push_back(8'hFF);
    for (int i = 0; i < 8; i++) m_hdr.push_back(sw[63-8*i -: 8]);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_cnt = 0; e_clear_n = 1; e_sel_n = 1; e_stb = 0;
      e_done = 0; e_fail = 0;
    end else begin
      e_done = 0;
      case (m_phase)
        0: if (start) begin
             m_partial = partial_mode;
             e_fail = 0;
             if (partial_mode) begin
               e_sel_n = 0; fill_header(); m_phase = 3;
             end else begin
               e_clear_n = 0; m_cnt = 0; m_phase = 1;
             end
           end
        1: begin
             m_cnt++;
             if (m_cnt == CLR_N) begin e_clear_n = 1; m_cnt = 0; m_phase = 2; end
           end
        2: if (tgt_ready) begin
             e_sel_n = 0; fill_header(); m_phase = 3;
           end else begin
             m_cnt++;
             if (m_cnt == WAIT_N) begin e_fail = 1; m_phase = 0; end
           end
        3: begin
             e_stb = 1; e_tag = "R5"; e_data = m_hdr.pop_front();
             if (m_hdr.size() == 0) m_phase = 4;
           end
        4: begin
             e_stb = s_valid; e_tag = "R6";
             if (s_valid) begin
               e_data = s_data;
               if (s_last) m_phase = 5;
             end
           end
        5: begin e_stb = 0; e_sel_n = 1; m_phase = 6; end
        6: begin e_done = 1; m_phase = 0; end
        default: m_phase = 0;
      endcase
    end
  end

  always @(posedge clk) if (!rst && done) done_cnt++;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(tgt_clear_n === e_clear_n, m_partial ? "R4" : "R2", "tgt_clear_n", 32'(tgt_clear_n), 32'(e_clear_n));
      chk(tgt_sel_n === e_sel_n, "R3", "tgt_sel_n", 32'(tgt_sel_n), 32'(e_sel_n));
      chk(tgt_wr_n === e_sel_n, "R3", "tgt_wr_n", 32'(tgt_wr_n), 32'(e_sel_n));
      chk(tgt_stb === e_stb, e_tag, "tgt_stb", 32'(tgt_stb), 32'(e_stb));
      if (e_stb) chk(tgt_data === e_data, e_tag, "tgt_data", 32'(tgt_data), 32'(e_data));
      chk(s_ready === (m_phase == 4), "R6", "s_ready", 32'(s_ready), 32'(m_phase == 4));
      chk(busy === (m_phase != 0), "R1", "busy", 32'(busy), 32'(m_phase != 0));
      chk(done === e_done, "R7", "done", 32'(done), 32'(e_done));
      chk(fail === e_fail, "R8", "fail", 32'(fail), 32'(e_fail));
      if (tgt_stb) chk(!tgt_sel_n && !tgt_wr_n, "R10", "strobe with port closed", 32'(tgt_sel_n), 32'h0);
    end
  end

  task automatic push_bytes(input int n, input int gap_every, input logic [7:0] base);
    int i = 0;
    int cyc = 0;
    while (i < n) begin
      @(negedge clk);
      if (gap_every != 0 && (cyc % gap_every) == gap_every - 1) begin
        s_valid = 0; s_last = 0;
      end else begin
        s_valid = 1; s_data = base + 8'(i); s_last = (i == n - 1);
      end
      cyc++;
      if (s_ready && s_valid) i++;
    end
    @(negedge clk);
    s_valid = 0; s_last = 0;
  endtask

  task automatic pulse_start(input bit part);
    @(negedge clk);
    start = 1; partial_mode = part;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(tgt_clear_n === 1'b1, "R1", "reset clear_n", 32'(tgt_clear_n), 32'h1);
    chk(tgt_sel_n === 1'b1 && tgt_wr_n === 1'b1, "R1", "reset sel/wr", 32'(tgt_sel_n), 32'h1);
    chk(tgt_stb === 1'b0 && s_ready === 1'b0, "R1", "reset stb/ready", 32'(tgt_stb), 32'h0);
    chk(busy === 1'b0 && done === 1'b0 && fail === 1'b0, "R1", "reset busy/done/fail", 32'(busy), 32'h0);
    rst = 0;

    // R4 R5 R6 R7: partial load, unbroken payload
    pulse_start(1'b1);
    push_bytes(3, 0, 8'h10);
    wait_idle();

    // R2 R3 R9: full load, ready late, gapped payload, mode changed mid-load
    @(negedge clk); start = 1; partial_mode = 0;
    @(negedge clk); start = 0; partial_mode = 1;
    repeat (CLR_N + 3) @(negedge clk);
    tgt_ready = 1;
    push_bytes(5, 3, 8'h40);
    wait_idle();
    tgt_ready = 0;

    // R8: full load whose ready never arrives
    pulse_start(1'b0);
    repeat (CLR_N + WAIT_N + 4) @(negedge clk);
    chk(fail === 1'b1 && busy === 1'b0, "R8", "timeout flag", 32'(fail), 32'h1);
    chk(tgt_sel_n === 1'b1, "R8", "port never opened", 32'(tgt_sel_n), 32'h1);

    // R9: start during a busy partial load is ignored; fail cleared by new start
    d0 = done_cnt;
    pulse_start(1'b1);
    chk(fail === 1'b0, "R8", "fail cleared by start", 32'(fail), 32'h0);
    @(negedge clk); start = 1; partial_mode = 0;
    @(negedge clk); start = 0;
    push_bytes(4, 2, 8'h80);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9", "done count after ignored start", 32'(done_cnt), 32'(d0 + 1));
    chk(busy === 1'b0 && tgt_clear_n === 1'b1, "R9", "idle after ignored start", 32'(busy), 32'h0);

    // R3: full load with ready already high
    tgt_ready = 1;
    pulse_start(1'b0);
    push_bytes(2, 0, 8'hC0);
    wait_idle();
    tgt_ready = 0;
    repeat (3) @(negedge clk);

    summary();
    $finish;
  end

endmodule